// File: doc/BRIEF.md
# Core Run-Control and Debug Register Block

This block is the host-facing control point of a small embedded processor core. A host uses a simple 32-bit register bus to start and stop the core, to step it one instruction at a time, to request a core reset, and to choose the address where fetching starts. It also reads two performance counters: one counts run cycles and one counts stall cycles.

The block drives an enable and a one-cycle reset request into the core. It also decodes a memory window for instruction memory and debug state. The run-state flag follows the core's own halted indication, not the enable bit, so it stays set until the core has really stopped. While the flag is set, every host access to the memory window is refused with an error and read data of zero. Once the core has halted, accesses pass straight through to the memory.

Top module: `core_runctl_regs`

## Requirements
- R1: After reset the control word reads 0x0000_0001, both counters read 0, and `core_enable`, `core_reset_req` and `host_lockout` are 0.
- R2: Control word fields: bits 31:16 hold the fetch start address, bit 15 run-state (read-only), bit 8 single-step, bit 3 counter-enable, bit 2 sleeping, bit 1 enable, and bit 0 soft-reset. Soft-reset always reads 1, and every other bit reads 0. `core_start_pc` and `core_enable` follow the stored start address and enable bit.
- R3: Run-state (`host_lockout`) becomes 1 on the clock edge after the edge where enable becomes 1.
- R4: Run-state returns to 0 only on an edge where enable is 0 and `core_halted` is 1. Otherwise it holds at 1.
- R5: A `core_halt_op` pulse clears enable on the next edge.
- R6: With single-step set, a `core_retire` pulse clears enable on the next edge. With single-step clear, `core_retire` leaves enable unchanged.
- R7: A control write with bit 0 = 0 raises `core_reset_req` for exactly the one cycle after the write edge.
- R8: The cycle counter (offset 0xC) adds 1 on each edge where counter-enable and run-state are both 1, and holds otherwise.
- R9: The stall counter (offset 0x10) adds 1 on each edge where counter-enable and `core_stall` are both 1, and holds otherwise.
- R10: Each counter stops at 0xFFFF_FFFF instead of wrapping. A host write to a counter loads the written value.
- R11: An access with address bit 12 = 1 reaches the memory window. While run-state is 1, it returns data 0 with `host_err` = 1, and `mem_sel` stays 0, so writes are dropped. While run-state is 0, `mem_sel` = 1, `host_rdata` = `mem_rdata` and `host_err` = 0.
- R12: Offset 0x4 reads `core_pc`, zero-extended. Offset 0x8 is a read/write register driving `core_wake_en`. Any other register offset reads 0 with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Byte address; bit 12 selects the memory window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the same cycle as `host_sel` |
| host_err | output | 1 | Error response for a refused access |
| mem_sel | output | 1 | Forwarded memory-window access strobe |
| mem_wr | output | 1 | Forwarded memory-window write |
| mem_rdata | input | 32 | Memory-window read data |
| core_enable | output | 1 | Run request to the core |
| core_reset_req | output | 1 | One-cycle reset request to the core |
| core_start_pc | output | 16 | Fetch address used after a core reset |
| core_wake_en | output | 32 | Wake-up enable mask |
| core_pc | input | 16 | Current core program counter |
| core_retire | input | 1 | An instruction retired this cycle |
| core_halt_op | input | 1 | A halt instruction retired this cycle |
| core_halted | input | 1 | The core is actually stopped |
| core_stall | input | 1 | The core is stalled this cycle |
| host_lockout | output | 1 | Run-state; 1 refuses memory-window access |

## Verification
Read data and the error flag are combinational, so they are sampled 1 ns after the access is presented at the falling edge. A write takes effect at the next rising edge. Enable, the reset request and counter loads are therefore checked at the falling edge that follows that rising edge. Run-state trails enable by one more edge, so it is checked one falling edge later still. Counter rates are measured as the difference between two reads that are a known number of rising edges apart, which makes the checks independent of when counting began.

// File: rtl/core_runctl_regs.sv
module core_runctl_regs #(
  parameter int ADDR_W = 13,
  parameter int PC_W   = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_err,
  output logic              mem_sel,
  output logic              mem_wr,
  input  logic [31:0]       mem_rdata,
  output logic              core_enable,
  output logic              core_reset_req,
  output logic [PC_W-1:0]   core_start_pc,
  output logic [31:0]       core_wake_en,
  input  logic [PC_W-1:0]   core_pc,
  input  logic              core_retire,
  input  logic              core_halt_op,
  input  logic              core_halted,
  input  logic              core_stall,
  output logic              host_lockout
);
  localparam int RA_W = ADDR_W - 1;
  localparam logic [RA_W-1:0] OFF_CTRL = RA_W'(0);
  localparam logic [RA_W-1:0] OFF_STAT = RA_W'(4);
  localparam logic [RA_W-1:0] OFF_WAKE = RA_W'(8);
  localparam logic [RA_W-1:0] OFF_CYC  = RA_W'(12);
  localparam logic [RA_W-1:0] OFF_STL  = RA_W'(16);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PC_W-1:0]  pc_base;
  logic             step, cnt_en, sleeping, enable, run_state, rst_pulse;
  logic [31:0]      wake;
  logic [CNT_W-1:0] cyc_cnt, stl_cnt;
  logic [31:0]      reg_rd;

  wire             in_mem = host_addr[ADDR_W-1];
  wire [RA_W-1:0]  roff   = host_addr[RA_W-1:0];
  wire             reg_wr = host_sel && host_wr && !in_mem;
  wire             wr_ctl = reg_wr && roff == OFF_CTRL;
  wire             wr_wk  = reg_wr && roff == OFF_WAKE;
  wire             wr_cyc = reg_wr && roff == OFF_CYC;
  wire             wr_stl = reg_wr && roff == OFF_STL;

  logic unused_wbits;
  assign unused_wbits = ^{host_wdata[14:9], host_wdata[7:4], host_wdata[15]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_base  <= '0;
      step     <= 1'b0;
      cnt_en   <= 1'b0;
      sleeping <= 1'b0;
      enable   <= 1'b0;
    end else if (wr_ctl) begin
      pc_base  <= host_wdata[16 +: PC_W];
      step     <= host_wdata[8];
      cnt_en   <= host_wdata[3];
      sleeping <= host_wdata[2];
      enable   <= host_wdata[1];
    end else if (core_halt_op || (step && core_retire)) begin
      enable   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_state <= 1'b0;
      rst_pulse <= 1'b0;
      wake      <= '0;
    end else begin
      if (enable)           run_state <= 1'b1;
      else if (core_halted) run_state <= 1'b0;
      rst_pulse <= wr_ctl && !host_wdata[0];
      if (wr_wk) wake <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
      stl_cnt <= '0;
    end else begin
      if (wr_cyc)
        cyc_cnt <= host_wdata[CNT_W-1:0];
      else if (cnt_en && run_state && cyc_cnt != CNT_MAX)
        cyc_cnt <= cyc_cnt + 1'b1;
      if (wr_stl)
        stl_cnt <= host_wdata[CNT_W-1:0];
      else if (cnt_en && core_stall && stl_cnt != CNT_MAX)
        stl_cnt <= stl_cnt + 1'b1;
    end
  end

  always_comb begin
    case (roff)
      OFF_CTRL: reg_rd = 32'({pc_base, run_state, 6'b0, step, 4'b0,
                              cnt_en, sleeping, enable, 1'b1});
      OFF_STAT: reg_rd = 32'(core_pc);
      OFF_WAKE: reg_rd = wake;
      OFF_CYC:  reg_rd = 32'(cyc_cnt);
      OFF_STL:  reg_rd = 32'(stl_cnt);
      default:  reg_rd = '0;
    endcase
  end

  assign mem_sel        = host_sel && in_mem && !run_state;
  assign mem_wr         = mem_sel && host_wr;
  assign host_err       = host_sel && in_mem && run_state;
  assign host_rdata     = !host_sel ? '0 : in_mem ? (mem_sel ? mem_rdata : '0) : reg_rd;
  assign core_enable    = enable;
  assign core_reset_req = rst_pulse;
  assign core_start_pc  = pc_base;
  assign core_wake_en   = wake;
  assign host_lockout   = run_state;
endmodule

// File: rtl/core_runctl_regs_chk.sv
module core_runctl_regs_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [31:0]       host_wdata,
  input logic [31:0]       host_rdata,
  input logic              host_err,
  input logic              mem_sel,
  input logic              mem_wr,
  input logic [31:0]       mem_rdata,
  input logic              core_enable,
  input logic              core_reset_req,
  input logic              core_halt_op,
  input logic              core_halted,
  input logic              host_lockout
);
  wire ctl_wr = host_sel && host_wr && host_addr == '0;
  wire win    = host_sel && host_addr[ADDR_W-1];

  assert_run_after_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_enable && !host_lockout) |=> host_lockout);

  assert_hold_until_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_lockout && !core_halted) |=> host_lockout);

  assert_halt_clears_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt_op && !ctl_wr) |=> !core_enable);

  assert_reset_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_reset_req && !(ctl_wr && !host_wdata[0])) |=> !core_reset_req);

  assert_window_refused_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (win && host_lockout) |-> (host_err && host_rdata == '0 && !mem_sel && !mem_wr));

  assert_window_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !host_lockout) |-> (!host_err && mem_sel && host_rdata == mem_rdata));
endmodule

bind core_runctl_regs core_runctl_regs_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/core_runctl_regs_tb_top.sv
module core_runctl_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_sel = 0, host_wr = 0;
  logic [12:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata, mem_rdata = 32'h5A5A_1234, core_wake_en;
  logic host_err, mem_sel, mem_wr, core_enable, core_reset_req, host_lockout;
  logic [15:0] core_start_pc, core_pc = 16'h1234;
  logic core_retire = 0, core_halt_op = 0, core_halted = 1, core_stall = 0;
  int total = 0, bad = 0;
  logic [31:0] a, b;
  logic e;

  always #4 clk = ~clk;

  core_runctl_regs dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] ad, logic [31:0] d);
    host_sel = 1; host_wr = 1; host_addr = ad; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic rd(logic [12:0] ad, output logic [31:0] d, output logic er);
    host_sel = 1; host_wr = 0; host_addr = ad;
    #1 d = host_rdata; er = host_err;
    host_sel = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(13'h0, a, e); check("R1 ctrl reset", a, 32'h0000_0001);
    rd(13'hC, a, e); check("R1 cycle reset", a, 0);
    rd(13'h10, a, e); check("R1 stall reset", a, 0);
    check("R1 outputs", {core_enable, core_reset_req, host_lockout}, 0);

    for (int i = 1; i <= 8; i++) begin
      logic [31:0] w;
      w = (32'h9E37_79B9 * i) & ~32'h2;
      wr(13'h0, w);
      check("R7 reset pulse", core_reset_req, !w[0]);
      rd(13'h0, a, e); check("R2 ctrl fields", a, (w & 32'hFFFF_010C) | 1);
      check("R2 start pc", core_start_pc, w[31:16]);
      @(negedge clk);
      check("R7 pulse ends", core_reset_req, 0);
    end

    rd(13'h4, a, e); check("R12 status", a, 32'h0000_1234);
    wr(13'h8, 32'hDEAD_BEEF);
    rd(13'h8, a, e); check("R12 wake read", a, 32'hDEAD_BEEF);
    check("R12 wake out", core_wake_en, 32'hDEAD_BEEF);
    rd(13'h14, a, e); check("R12 unmapped", {a[30:0], e}, 0);

    host_sel = 1; host_addr = 13'h1000; #1;
    check("R11 open sel", {mem_sel, host_err}, 2'b10);
    check("R11 open data", host_rdata, 32'h5A5A_1234);
    host_sel = 0;

    wr(13'h0, 32'h0000_000B);
    check("R2 enable out", core_enable, 1);
    check("R3 not yet", host_lockout, 0);
    @(negedge clk);
    check("R3 run state", host_lockout, 1);
    core_halted = 0;
    rd(13'h0, a, e); check("R2 run bit", a, 32'h0000_800B);

    rd(13'hC, a, e);
    repeat (7) @(negedge clk);
    rd(13'hC, b, e); check("R8 cycle rate", b - a, 7);

    core_retire = 1; @(negedge clk); core_retire = 0;
    check("R6 no step keeps enable", core_enable, 1);

    rd(13'h10, a, e);
    core_stall = 1; repeat (5) @(negedge clk); core_stall = 0;
    rd(13'h10, b, e); check("R9 stall rate", b - a, 5);

    rd(13'h1000, a, e); check("R11 locked read", {a[30:0], e}, 1);
    host_sel = 1; host_wr = 1; host_addr = 13'h1000; #1;
    check("R11 locked write", {mem_sel, mem_wr, host_err}, 3'b001);
    @(negedge clk); host_sel = 0; host_wr = 0;

    wr(13'h0, 32'h0000_0003);
    rd(13'hC, a, e); rd(13'h10, b, e);
    core_stall = 1; repeat (4) @(negedge clk); core_stall = 0;
    rd(13'hC, host_wdata, e); check("R8 gated off", host_wdata - a, 0);
    rd(13'h10, host_wdata, e); check("R9 gated off", host_wdata - b, 0);

    core_halt_op = 1; @(negedge clk); core_halt_op = 0;
    check("R5 halt clears", core_enable, 0);
    repeat (3) @(negedge clk);
    check("R4 waits for halted", host_lockout, 1);
    core_halted = 1; @(negedge clk);
    check("R4 halted clears", host_lockout, 0);

    wr(13'h0, 32'h0000_0103);
    @(negedge clk); core_halted = 0;
    repeat (2) @(negedge clk);
    check("R6 step waits", core_enable, 1);
    core_retire = 1; @(negedge clk); core_retire = 0;
    check("R6 step clears", core_enable, 0);
    check("R4 step still running", host_lockout, 1);
    core_halted = 1; @(negedge clk);
    check("R4 step halted", host_lockout, 0);

    wr(13'hC, 32'hFFFF_FFFD);
    rd(13'hC, a, e); check("R10 load", a, 32'hFFFF_FFFD);
    wr(13'h10, 32'hFFFF_FFFE);
    wr(13'h0, 32'h0000_000B); core_halted = 0;
    core_stall = 1; repeat (8) @(negedge clk); core_stall = 0;
    rd(13'hC, a, e); check("R10 cycle saturates", a, 32'hFFFF_FFFF);
    rd(13'h10, a, e); check("R10 stall saturates", a, 32'hFFFF_FFFF);
    finish_run();
  end
endmodule